// File: doc/BRIEF.md
# DMA Channel Register Interface

This block holds the per-channel programming registers of a four-channel DMA engine. Each channel has a 16-bit base address register and a 16-bit word count register. The host reaches them through an 8-bit data port and a 4-bit port offset, so each 16-bit value takes two byte accesses. One byte-order pointer decides whether an access reaches the low byte or the high byte. All eight registers share that pointer, and both reads and writes advance it.

Three write-only command offsets act on the shared control state. One returns the pointer to the low byte. One is a master clear: it rewinds the pointer, masks every channel and empties the status register. One unmasks all channels. The channel mask bits and the 8-bit status register are driven out so that the transfer engine can use them. The status bits are sticky: the engine sets them through `stat_set`, and only a master clear or reset clears them.

Top module: `dma_chan_regs`

## Requirements
- R1: For offsets 0..7, bits [2:1] of `addr` pick the channel. Bit 0 picks the register: 0 is the base address, 1 is the word count.
- R2: A single byte pointer serves all registers. When it is low, an access uses bits [7:0]; when it is high, an access uses bits [15:8]. Every register access toggles the pointer after the access, including accesses that alternate between different channels or registers.
- R3: While `rd_en` is high, `wr_en` is low and the offset is 0..7, `rdata` shows the selected byte in the same cycle. In every other cycle `rdata` is 0. A read toggles the pointer in the same way a write does.
- R4: When `wr_en` and `rd_en` are both high, the cycle is handled as a write alone. The pointer toggles once and `rdata` is 0.
- R5: A write to offset 0xD is a master clear. It sets the pointer to low, sets `mask` to 4'b1111 and sets `status` to 0. The address and count registers keep their values.
- R6: A write to offset 0xC sets the pointer to low and changes nothing else.
- R7: A write to offset 0xE sets `mask` to 4'b0000 and changes nothing else.
- R8: Each `stat_set` bit sets the matching `status` bit on the next clock edge, and that bit then holds. A master clear in the same cycle takes priority.
- R9: A synchronous active-high `rst` clears all address and count registers to 0, sets the pointer to low, sets `mask` to 4'b1111 and sets `status` to 0.
- R10: A write to offsets 0x8..0xB or 0xF, or a read of any offset 0x8..0xF, changes no register, no mask bit, no status bit and not the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Port offset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wdata | input | 8 | Write data byte |
| stat_set | input | 8 | Status bit set requests from the transfer engine |
| rdata | output | 8 | Read data byte, combinational |
| mask | output | 4 | Channel mask bits, 1 = masked |
| status | output | 8 | Sticky status bits |

## Verification
The pointer cannot be seen at any port. A pointer that is out of step shows up only on the next register read, which returns the other byte of the register. If writes get out of step, the value lands in the wrong half and shows up on the read-back of that half. The bench therefore reads back after every kind of disturbance: interleaved channels, unimplemented offsets, both strobes high at once, and the command offsets. A fault in a mask or status bit shows at its output port one clock after the command that caused it.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  localparam logic [3:0] OFS_PTR_RST = 4'hC;
  localparam logic [3:0] OFS_MCLR    = 4'hD;
  localparam logic [3:0] OFS_UNMASK  = 4'hE;

  typedef struct packed {
    logic reg_wr;
    logic reg_rd;
    logic ptr_rst;
    logic mclr;
    logic unmask;
  } dma_evt_t;

  function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi);
    return hi ? w[WORD_W-1:BYTE_W] : w[BYTE_W-1:0];
  endfunction

  function automatic logic [WORD_W-1:0] merge_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
    return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
  endfunction

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [3:0]      addr,
  output dma_evt_t        evt,
  output logic [CH_W-1:0] ch_sel,
  output logic            is_count
);
  localparam logic [4:0] REG_SPAN = 5'(2 * NUM_CH);

  logic in_regs;

  assign in_regs  = {1'b0, addr} < REG_SPAN;
  assign ch_sel   = addr[CH_W:1];
  assign is_count = addr[0];

  always_comb begin
    evt         = '0;
    evt.reg_wr  = wr_en && in_regs;
    evt.reg_rd  = rd_en && !wr_en && in_regs;
    evt.ptr_rst = wr_en && (addr == OFS_PTR_RST);
    evt.mclr    = wr_en && (addr == OFS_MCLR);
    evt.unmask  = wr_en && (addr == OFS_UNMASK);
  end
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic rewind,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (rst || rewind) hi <= 1'b0;
    else if (step)     hi <= ~hi;
  end
endmodule

// File: rtl/dma_reg_file.sv
module dma_reg_file
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CH_W-1:0]   ch_sel,
  input  logic              is_count,
  input  logic              hi,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte
);
  logic [WORD_W-1:0] base_arr [NUM_CH];
  logic [WORD_W-1:0] cnt_arr  [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [WORD_W-1:0] base_q, cnt_q;
    logic hit;
    assign hit = wr && (ch_sel == CH_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        base_q <= '0;
        cnt_q  <= '0;
      end else if (hit) begin
        if (is_count) cnt_q  <= merge_byte(cnt_q, hi, wdata);
        else          base_q <= merge_byte(base_q, hi, wdata);
      end
    end

    assign base_arr[g] = base_q;
    assign cnt_arr[g]  = cnt_q;
  end

  assign rd_byte = pick_byte(is_count ? cnt_arr[ch_sel] : base_arr[ch_sel], hi);
endmodule

// File: rtl/dma_ctrl_state.sv
module dma_ctrl_state #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              unmask,
  input  logic [STAT_W-1:0] stat_set,
  output logic [NUM_CH-1:0] mask,
  output logic [STAT_W-1:0] status
);
  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      mask   <= '1;
      status <= '0;
    end else begin
      status <= status | stat_set;
      if (unmask) mask <= '0;
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned STAT_W = 8,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [STAT_W-1:0] stat_set,
  output logic [BYTE_W-1:0] rdata,
  output logic [NUM_CH-1:0] mask,
  output logic [STAT_W-1:0] status
);
  dma_evt_t          evt;
  logic [CH_W-1:0]   ch_sel;
  logic              is_count;
  logic              ptr_hi;
  logic              reg_step;
  logic              ptr_rewind;
  logic [BYTE_W-1:0] rd_byte;

  dma_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .evt(evt), .ch_sel(ch_sel), .is_count(is_count)
  );

  assign reg_step   = evt.reg_wr | evt.reg_rd;
  assign ptr_rewind = evt.ptr_rst | evt.mclr;

  dma_byte_ptr u_ptr (
    .clk(clk), .rst(rst), .step(reg_step), .rewind(ptr_rewind), .hi(ptr_hi)
  );

  dma_reg_file #(.NUM_CH(NUM_CH)) u_rf (
    .clk(clk), .rst(rst), .wr(evt.reg_wr), .ch_sel(ch_sel),
    .is_count(is_count), .hi(ptr_hi), .wdata(wdata), .rd_byte(rd_byte)
  );

  dma_ctrl_state #(.NUM_CH(NUM_CH), .STAT_W(STAT_W)) u_ctl (
    .clk(clk), .rst(rst), .mclr(evt.mclr), .unmask(evt.unmask),
    .stat_set(stat_set), .mask(mask), .status(status)
  );

  assign rdata = evt.reg_rd ? rd_byte : '0;
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [STAT_W-1:0] stat_set,
  input logic [NUM_CH-1:0] mask,
  input logic [STAT_W-1:0] status,
  input logic              ptr_hi
);
  logic reg_acc, unimpl;
  assign reg_acc = (wr_en || rd_en) && (addr < 4'(2 * NUM_CH));
  assign unimpl  = (wr_en && (addr >= 4'h8) && (addr <= 4'hB || addr == 4'hF)) ||
                   (rd_en && !wr_en && addr >= 4'h8);

  // R2
  ptr_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    reg_acc |=> ptr_hi != $past(ptr_hi));

  // R5
  mclr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hD) |=> !ptr_hi && mask == '1 && status == '0);

  // R6
  ptr_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hC) |=> !ptr_hi && $stable(mask));

  // R7
  unmask_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 4'hE) |=> mask == '0);

  // R3
  rdata_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || wr_en) |-> rdata == '0);

  // R10
  unimpl_chk: assert property (@(posedge clk) disable iff (rst)
    (unimpl && stat_set == '0) |=> $stable(ptr_hi) && $stable(mask) && $stable(status));

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 4'hD) |=> (status & $past(status | stat_set)) == $past(status | stat_set));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NUM_CH(NUM_CH), .STAT_W(STAT_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .stat_set(stat_set), .mask(mask), .status(status),
  .ptr_hi(ptr_hi)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, stat_set;
  logic [7:0] rdata;
  logic [3:0] mask;
  logic [7:0] status;

  int n_checks = 0;
  int n_errs   = 0;

  always #4 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .stat_set(stat_set), .rdata(rdata), .mask(mask), .status(status)
  );

  // reference model
  int m_base[4];
  int m_cnt[4];
  bit m_hi;
  int m_mask;
  int m_stat;

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_rdata(bit w, bit r, int a);
    int word;
    if (!r || w || a >= 8) return 0;
    word = (a % 2 == 1) ? m_cnt[a / 2] : m_base[a / 2];
    return m_hi ? (word / 256) % 256 : word % 256;
  endfunction

  task automatic model_clock(bit rs, bit w, bit r, int a, int d, int s);
    int idx;
    if (rs) begin
      for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_cnt[i] = 0; end
      m_hi = 0; m_mask = 15; m_stat = 0;
      return;
    end
    if (w && a < 8) begin
      idx = a / 2;
      if (a % 2 == 1) m_cnt[idx]  = m_hi ? (m_cnt[idx] % 256) + d * 256 : (m_cnt[idx] / 256) * 256 + d;
      else            m_base[idx] = m_hi ? (m_base[idx] % 256) + d * 256 : (m_base[idx] / 256) * 256 + d;
      m_hi = !m_hi;
    end else if (r && !w && a < 8) begin
      m_hi = !m_hi;
    end
    if (w && a == 12) m_hi = 0;
    if (w && a == 13) begin
      m_hi = 0; m_mask = 15; m_stat = 0;
    end else begin
      m_stat = m_stat | s;
    end
    if (w && a == 14) m_mask = 0;
  endtask

  // one cycle: drive after falling edge, compare, then advance the model at the rising edge
  task automatic step(string req, bit w, bit r, int a, int d = 0, int s = 0, bit rs = 0);
    @(negedge clk);
    rst = rs; wr_en = w; rd_en = r; addr = 4'(a); wdata = 8'(d); stat_set = 8'(s);
    #1;
    if (!rs) check({req, " rdata"}, int'(rdata), ref_rdata(w, r, a));
    check({req, " mask"}, int'(mask), m_mask);
    check({req, " status"}, int'(status), m_stat);
    @(posedge clk);
    model_clock(rs, w, r, a, d, s);
  endtask

  task automatic wr(string req, int a, int d); step(req, 1, 0, a, d); endtask
  task automatic rd(string req, int a);        step(req, 0, 1, a);    endtask

  initial begin
    #1500000;
    n_errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks + 1);
    $finish;
  end

  initial begin
    rst = 1; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; stat_set = 0;
    m_hi = 0; m_mask = 15; m_stat = 0;
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_cnt[i] = 0; end
    step("R9", 0, 0, 0, 0, 0, 1);
    step("R9", 0, 0, 0, 0, 0, 1);
    // R9 reset state: registers read zero, mask set
    rd("R9", 0); rd("R9", 0); rd("R9", 7); rd("R9", 7);
    // R1 R2: fill every register low then high
    for (int a = 0; a < 8; a++) begin
      wr("R1", a, 16 * a + 1);
      wr("R2", a, 16 * a + 2);
    end
    for (int a = 7; a >= 0; a--) begin rd("R1", a); rd("R3", a); end
    // R2: interleave, low byte to ch1 base then read ch2 count high
    wr("R2", 2, 8'hAA); rd("R2", 5); rd("R2", 2); rd("R2", 2);
    // R10: unimplemented offsets between bytes
    wr("R10", 0, 8'h11); wr("R10", 9, 8'hFF); step("R10", 0, 1, 4'hC);
    step("R10", 0, 1, 4'hD); wr("R10", 15, 8'h5A); wr("R10", 0, 8'h22);
    rd("R10", 0); rd("R10", 0);
    // R4: both strobes
    step("R4", 1, 1, 3, 8'h77); step("R4", 1, 1, 3, 8'h66); rd("R4", 3); rd("R4", 3);
    // R6: pointer reset mid-pair
    wr("R6", 4, 8'h01); wr("R6", 12, 0); wr("R6", 4, 8'h02); rd("R6", 4); rd("R6", 4);
    // R7 / R5
    wr("R7", 14, 0); step("R8", 0, 0, 0, 0, 8'h81); step("R8", 0, 0, 0, 0, 8'h10);
    step("R8", 0, 0, 0, 0, 0);
    wr("R5", 6, 8'h33); wr("R5", 13, 0); rd("R5", 6); rd("R5", 6);
    step("R8", 1, 0, 13, 0, 8'hFF); step("R8", 0, 0, 0, 0, 0);
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int a; bit w, r;
      a = $urandom_range(0, 15);
      w = ($urandom_range(0, 3) == 0);
      r = ($urandom_range(0, 1) == 1);
      if (a == 13 && $urandom_range(0, 7) != 0) w = 0;
      step("R2", w, r, a, $urandom_range(0, 255),
           ($urandom_range(0, 15) == 0) ? $urandom_range(0, 255) : 0,
           ($urandom_range(0, 499) == 0));
    end
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule